// File: doc/BRIEF.md
# Flag-Based Branch Resolution Unit

This block picks the next fetch address for a simple 32-bit pipelined core. It holds one condition flag, T. Compare operations write T, and conditional branches read it. Ordinary arithmetic leaves T alone. Each cycle the decoder presents one operation: an operation class, two register operands, a displacement that is already sign-extended, and the address of the operation. The block then returns the next program counter as combinational logic in that same cycle. T, the pending branch target and the controller state change on the following clock edge.

Branches come in two forms. An immediate branch redirects fetch at once. A delayed branch first lets the next operation, called the slot operation, run, and only then moves fetch to the target. An unconditional jump is always delayed. Conditional branches exist in both forms.

The controller has two states. LINEAR means no redirect is owed. SLOT means a delayed branch was taken and its target is waiting. LINEAR goes to SLOT when a valid unconditional jump arrives, or when a valid delayed conditional branch arrives and its condition holds. SLOT goes back to LINEAR on the next valid operation, which is the slot operation. When op_valid is low, the state does not change.

Top module: `flag_branch_unit`

## Requirements
- R1: After reset, t_flag is 0 and slot_pending is 0.
- R2: op_class 1 with cmp_unsigned=0 is a signed two's-complement greater-or-equal compare. On the next edge, T becomes 1 if opnd_a >= opnd_b and 0 otherwise.
- R3: op_class 1 with cmp_unsigned=1 makes the same comparison with both operands read as unsigned.
- R4: op_class 2 is an equality compare. T becomes 1 if opnd_a equals opnd_b (including both being zero) and 0 otherwise.
- R5: op_class 0 (plain operation) leaves T unchanged, and next_pc is cur_pc+4. When op_valid is 0, next_pc equals cur_pc, and neither T nor slot_pending changes.
- R6: The branch target is always cur_pc + 4 + 2*disp, with disp read as signed.
- R7: op_class 3 (unconditional jump) gives next_pc = cur_pc+4 and raises slot_pending. The next valid operation gets next_pc equal to the stored target and clears slot_pending.
- R8: op_class 4 (branch if T=1) and op_class 5 (branch if T=0) use T as it stood before the operation. When the condition holds, next_pc is the target; otherwise it is cur_pc+4. Neither opens a slot.
- R9: op_class 6 (delayed branch if T=1) and op_class 7 (delayed branch if T=0) behave like R7 when the condition holds. Otherwise they give cur_pc+4 and leave slot_pending at 0.
- R10: If a valid operation of class 3 to 7 arrives while slot_pending is 1, slot_fault is asserted in that cycle. That branch is not taken: next_pc is the stored target and slot_pending clears.
- R11: A compare placed in the slot runs normally and updates T, while next_pc is the stored target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation executes this cycle |
| op_class | input | 3 | Operation class, coded 0 to 7 as in the requirements |
| cmp_unsigned | input | 1 | Selects the unsigned greater-or-equal compare |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| disp | input | 32 | Sign-extended branch displacement, counted in halfwords |
| cur_pc | input | 32 | Address of the current operation |
| next_pc | output | 32 | Next fetch address |
| t_flag | output | 1 | Current T flag |
| slot_pending | output | 1 | A delayed redirect is owed (SLOT state) |
| slot_fault | output | 1 | A branch was found in a delay slot |

## Verification
The greater-or-equal compare is driven with operand pairs that have opposite signs, so the signed and unsigned readings disagree, and with pairs of equal operands, so the boundary of the comparison is exercised. The equality compare is given zero against zero and also neighbouring unequal values. Branches run under both values of T and with negative and positive displacements. This separates taken from not-taken, immediate from delayed, and a wrong target from a correct one. Stall cycles placed inside a pending slot, a compare placed in a slot, and a branch placed in a slot show whether the stored target survives a stall, whether the slot operation really executes, and whether a branch in a slot is ignored.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    typedef enum logic [2:0] {
        OPC_PLAIN  = 3'd0,
        OPC_CMP_GE = 3'd1,
        OPC_CMP_EQ = 3'd2,
        OPC_JMP_D  = 3'd3,
        OPC_BT     = 3'd4,
        OPC_BF     = 3'd5,
        OPC_BT_D   = 3'd6,
        OPC_BF_D   = 3'd7
    } opc_e;

    typedef enum logic {
        ST_LINEAR = 1'b0,
        ST_SLOT   = 1'b1
    } fsm_e;

    function automatic logic is_branch(opc_e o);
        return (o == OPC_JMP_D) || (o == OPC_BT) || (o == OPC_BF) ||
               (o == OPC_BT_D) || (o == OPC_BF_D);
    endfunction

    function automatic logic is_compare(opc_e o);
        return (o == OPC_CMP_GE) || (o == OPC_CMP_EQ);
    endfunction

endpackage

// File: rtl/fbu_cmp.sv
module fbu_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         use_unsigned,
    input  logic         sel_eq,
    output logic         hit
);
    logic ge_s;
    logic ge_u;
    logic eq;

    always_comb begin
        ge_s = ($signed(lhs) >= $signed(rhs));
        ge_u = (lhs >= rhs);
        eq   = (lhs == rhs);
        if (sel_eq)            hit = eq;
        else if (use_unsigned) hit = ge_u;
        else                   hit = ge_s;
    end

    always_comb begin
        if (eq) begin
            AST_EQ_IMPLIES_GE: assert (ge_s && ge_u); // R4
        end
    end

endmodule

// File: rtl/fbu_target.sv
module fbu_target #(
    parameter int W          = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] disp,
    output logic [W-1:0] seq_pc,
    output logic [W-1:0] tgt_pc
);
    localparam logic [W-1:0] STEP = W'(STEP_BYTES);

    always_comb begin
        seq_pc = pc + STEP;
        tgt_pc = seq_pc + {disp[W-2:0], 1'b0};
    end

endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_class,
    input  logic            cmp_unsigned,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [XLEN-1:0] disp,
    input  logic [XLEN-1:0] cur_pc,
    output logic [XLEN-1:0] next_pc,
    output logic            t_flag,
    output logic            slot_pending,
    output logic            slot_fault
);
    import fbu_pkg::*;

    opc_e            opc;
    fsm_e            state, state_d;
    logic            t_q, t_d;
    logic [XLEN-1:0] tgt_q, tgt_d;
    logic [XLEN-1:0] seq_pc, tgt_pc;
    logic            cmp_hit;
    logic            cond_true;

    assign opc = opc_e'(op_class);

    fbu_cmp #(.W(XLEN)) u_cmp (
        .lhs          (opnd_a),
        .rhs          (opnd_b),
        .use_unsigned (cmp_unsigned),
        .sel_eq       (opc == OPC_CMP_EQ),
        .hit          (cmp_hit)
    );

    fbu_target #(.W(XLEN), .STEP_BYTES(INSN_BYTES)) u_tgt (
        .pc     (cur_pc),
        .disp   (disp),
        .seq_pc (seq_pc),
        .tgt_pc (tgt_pc)
    );

    // Branch condition against T as it stood before this operation.
    always_comb begin
        unique case (opc)
            OPC_BT, OPC_BT_D: cond_true = t_q;
            OPC_BF, OPC_BF_D: cond_true = !t_q;
            OPC_JMP_D:        cond_true = 1'b1;
            default:          cond_true = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LINEAR;
            t_q   <= 1'b0;
            tgt_q <= '0;
        end else begin
            state <= state_d;
            t_q   <= t_d;
            tgt_q <= tgt_d;
        end
    end

    // Next state, flag and stored target
    always_comb begin
        state_d = state;
        t_d     = t_q;
        tgt_d   = tgt_q;
        if (op_valid) begin
            if (is_compare(opc)) t_d = cmp_hit;
            unique case (state)
                ST_LINEAR: begin
                    if ((opc == OPC_JMP_D || opc == OPC_BT_D || opc == OPC_BF_D) && cond_true) begin
                        state_d = ST_SLOT;
                        tgt_d   = tgt_pc;
                    end
                end
                ST_SLOT: begin
                    state_d = ST_LINEAR;
                end
                default: state_d = ST_LINEAR;
            endcase
        end
    end

    // Outputs
    always_comb begin
        next_pc      = cur_pc;
        slot_fault   = 1'b0;
        t_flag       = t_q;
        slot_pending = (state == ST_SLOT);
        if (op_valid) begin
            unique case (state)
                ST_LINEAR: begin
                    next_pc = seq_pc;
                    if ((opc == OPC_BT || opc == OPC_BF) && cond_true) next_pc = tgt_pc;
                end
                ST_SLOT: begin
                    next_pc    = tgt_q;
                    slot_fault = is_branch(opc);
                end
                default: next_pc = seq_pc;
            endcase
        end
    end

    AST_PLAIN_KEEPS_T: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 3'd0) |=> (t_flag == $past(t_flag))); // R5
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid) |=> ($stable(t_flag) && $stable(slot_pending))); // R5
    AST_JMP_OPENS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_pending && op_valid && op_class == 3'd3) |=> slot_pending); // R7
    AST_SLOT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_pending && op_valid) |=> !slot_pending); // R7
    AST_IMM_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_pending && op_valid && (op_class == 3'd4 || op_class == 3'd5)) |=> !slot_pending); // R8
    AST_FAULT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        slot_fault |-> (slot_pending && op_valid)); // R10

endmodule

// File: tb/flag_branch_unit_tb_top.sv
`timescale 1ns/1ps
module flag_branch_unit_tb_top;

    typedef struct {
        logic [31:0] nxt;
        logic        fault;
        logic        t;
        logic        pend;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic        cmp_unsigned = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0, disp = '0, cur_pc = '0;
    logic [31:0] next_pc;
    logic        t_flag, slot_pending, slot_fault;

    int checks = 0;
    int fails = 0;
    exp_t sb[$];

    logic        m_t = 1'b0;
    logic        m_pend = 1'b0;
    logic [31:0] m_tgt = '0;

    always #10 clk = ~clk;

    flag_branch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .cmp_unsigned(cmp_unsigned), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .disp(disp), .cur_pc(cur_pc), .next_pc(next_pc), .t_flag(t_flag),
        .slot_pending(slot_pending), .slot_fault(slot_fault)
    );

    task automatic apply(input logic v, input logic [2:0] oc, input logic u,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] d, input logic [31:0] pc, input string tag);
        exp_t e;
        logic [31:0] seq, tgt;
        logic cond, br;
        @(negedge clk);
        op_valid = v; op_class = oc; cmp_unsigned = u;
        opnd_a = a; opnd_b = b; disp = d; cur_pc = pc;
        seq  = pc + 32'd4;
        tgt  = seq + (d << 1);
        br   = (oc >= 3'd3);
        cond = (oc == 3'd3) || ((oc == 3'd4 || oc == 3'd6) && m_t) ||
               ((oc == 3'd5 || oc == 3'd7) && !m_t);
        e.t = m_t; e.pend = m_pend; e.tag = tag;
        e.fault = v && m_pend && br;
        if (!v)                                  e.nxt = pc;
        else if (m_pend)                         e.nxt = m_tgt;
        else if ((oc == 3'd4 || oc == 3'd5) && cond) e.nxt = tgt;
        else                                     e.nxt = seq;
        sb.push_back(e);
        if (v) begin
            if (oc == 3'd1) m_t = u ? (a >= b) : ($signed(a) >= $signed(b));
            if (oc == 3'd2) m_t = (a == b);
            if (m_pend) m_pend = 1'b0;
            else if ((oc == 3'd3 || oc == 3'd6 || oc == 3'd7) && cond) begin
                m_pend = 1'b1;
                m_tgt  = tgt;
            end
        end
    endtask

    // Monitor: pops one expected item per applied vector
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (next_pc !== e.nxt || slot_fault !== e.fault ||
                    t_flag !== e.t || slot_pending !== e.pend) begin
                    fails++;
                    $display("FAIL %s: next_pc=%h fault=%b t=%b pend=%b, expected next_pc=%h fault=%b t=%b pend=%b",
                             e.tag, next_pc, slot_fault, t_flag, slot_pending,
                             e.nxt, e.fault, e.t, e.pend);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (t_flag !== 1'b0 || slot_pending !== 1'b0) begin
            fails++;
            $display("FAIL R1: t=%b pend=%b, expected t=0 pend=0", t_flag, slot_pending);
        end
        @(negedge clk);
        rst_n = 1'b1;

        apply(1, 3'd0, 0, 32'd1, 32'd2, 32'd0, 32'h100, "R5 plain");
        apply(1, 3'd1, 0, 32'hFFFF_FFFF, 32'd5, 32'd0, 32'h104, "R2 signed ge neg<pos");
        apply(1, 3'd1, 0, 32'd5, 32'hFFFF_FFFF, 32'd0, 32'h108, "R2 signed ge pos>=neg");
        apply(1, 3'd0, 0, 32'd7, 32'd7, 32'd0, 32'h10C, "R5 plain keeps T");
        apply(1, 3'd4, 0, 32'd0, 32'd0, 32'hFFFF_FFF8, 32'h110, "R8 R6 bt taken neg disp");
        apply(1, 3'd5, 0, 32'd0, 32'd0, 32'd20, 32'h200, "R8 bf not taken");
        apply(1, 3'd1, 1, 32'd5, 32'hFFFF_FFFF, 32'd0, 32'h204, "R3 unsigned ge");
        apply(1, 3'd2, 0, 32'd0, 32'd0, 32'd0, 32'h208, "R4 eq zero");
        apply(1, 3'd2, 0, 32'd3, 32'd4, 32'd0, 32'h20C, "R4 eq unequal");
        apply(1, 3'd5, 0, 32'd0, 32'd0, 32'd6, 32'h210, "R8 R6 bf taken");
        apply(0, 3'd4, 0, 32'd0, 32'd0, 32'd6, 32'h220, "R5 stall");
        apply(1, 3'd3, 0, 32'd0, 32'd0, 32'h10, 32'h220, "R7 jmp");
        apply(1, 3'd2, 0, 32'd9, 32'd9, 32'd0, 32'h224, "R11 R7 cmp in slot");
        apply(1, 3'd6, 0, 32'd0, 32'd0, 32'h40, 32'h300, "R9 bt delayed taken");
        apply(0, 3'd0, 0, 32'd0, 32'd0, 32'd0, 32'h304, "R5 stall in slot");
        apply(1, 3'd4, 0, 32'd0, 32'd0, 32'h8, 32'h304, "R10 branch in slot");
        apply(1, 3'd7, 0, 32'd0, 32'd0, 32'h8, 32'h400, "R9 bf delayed not taken");
        apply(1, 3'd0, 0, 32'd0, 32'd0, 32'd0, 32'h404, "R9 no slot opened");
        apply(1, 3'd1, 1, 32'hFFFF_0000, 32'hFFFF_0000, 32'd0, 32'h408, "R3 unsigned equal");
        apply(1, 3'd1, 0, 32'hFFFF_FFFB, 32'hFFFF_FFFB, 32'd0, 32'h40C, "R2 signed equal");
        apply(1, 3'd1, 0, 32'h8000_0000, 32'h7FFF_FFFF, 32'd0, 32'h410, "R2 min vs max");
        apply(1, 3'd7, 0, 32'd0, 32'd0, 32'hFFFF_FFF0, 32'h500, "R9 bf delayed taken");
        apply(1, 3'd3, 0, 32'd0, 32'd0, 32'h100, 32'h504, "R10 jmp in slot");
        apply(1, 3'd0, 0, 32'd0, 32'd0, 32'd0, 32'h4E4, "R10 slot cleared");

        @(negedge clk);
        op_valid = 1'b0;
        wait (sb.size() == 0);
        #10;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule